// File: doc/BRIEF.md
# Microprogrammed control sequencer

This block is the control unit of a small accumulator CPU. It holds a 32-word microprogram store and a 5-bit microprogram counter. Every clock it registers one microinstruction, and the control field of that microinstruction drives the datapath directly. The control field is a 19-bit word made of twelve bus gate enables, a memory enable, a read/not-write line and five register load strobes (program counter, memory address register, memory buffer register, instruction register, accumulator). The datapath itself is outside the block. It feeds back a 4-bit instruction code taken from its instruction register, two accumulator flags and a halt request.

Each microinstruction carries three sequencing fields: a 5-bit next address, a 2-bit load-control code and a 2-bit condition selector. The sequencing modes are:
- step (00): advance by one word.
- jump (01): go to the next-address field.
- branch (10): go to the next-address field when the selected condition holds, otherwise step.
- dispatch (11): go to the routine entry that the opcode map gives.

The condition selector picks always-true (0), accumulator-zero (1), accumulator-negative (2) or halt-request (3).

The microprogram contains a fetch routine and several instruction routines.
- Fetch runs at words 0 to 4. Word 0 copies PC to MAR and branches to the halt routine when a halt is requested. Word 1 increments PC. Word 2 reads memory into MBR. Word 3 loads IR. Word 4 dispatches.
- Instruction routines: load-immediate (5), load-from-memory (6–8), add-immediate (9), add-from-memory (10–12), store (13–15), jump (16), jump-if-zero (17–18), jump-if-negative (19–20) and stop (21).
- Halt routine: words 30 and 31.
- Every instruction routine returns to word 0 with an unconditional jump, with one exception: stop parks on itself.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is held, `uaddr` is 0. The outputs then show word 0: `gate_en`=12'h001, `ld_mar`=1, every other load strobe 0, `mem_en`=0, `mem_rnw`=1.
- R2: Load-control 00 advances `uaddr` by exactly one. With no halt request, fetch visits words 1, 2, 3 and 4 in that order. Word 1 shows `ld_pc`=1 with `gate_en`=12'h002. Word 2 shows `mem_en`=1, `mem_rnw`=1, `ld_mbr`=1 with `gate_en`=12'h420. Word 3 shows `ld_ir`=1 with `gate_en`=12'h040. Word 4 asserts no load strobe.
- R3: Word 4 dispatches through the opcode map. The map uses `opcode[3:1]` as the operation and `opcode[0]` as an immediate flag. Entry points: 000 goes to 6 (flag 0) or 5 (flag 1); 001 goes to 10 (flag 0) or 9 (flag 1); 010 goes to 13; 011 goes to 16; 100 goes to 17; 101 goes to 19; 111 goes to 21.
- R4: Load-control 01 moves to the next-address field. Each instruction routine ends by returning to word 0. Load-immediate shows `ld_acc`=1 with `gate_en`=12'h008 at word 5. Add-from-memory reads at word 11 and loads the accumulator at word 12 with `gate_en`=12'hA40.
- R5: Load-control 10 with a true condition branches. Jump-if-zero (word 17, selector 1) with `acc_zero`=1 goes to 16. Jump-if-negative (word 19, selector 2) with `acc_neg`=1 goes to 16. Word 16 shows `ld_pc`=1 with `gate_en`=12'h100.
- R6: Load-control 10 with a false condition steps. Word 17 with `acc_zero`=0 goes to 18. Word 19 with `acc_neg`=0 goes to 20, even when `acc_zero`=1. Both words then return to 0.
- R7: A halt request seen at word 0 sends the sequencer to word 30. It stays there while the request remains. Once the request drops, it goes to word 31 and then to word 0.
- R8: The stop routine (word 21) holds `uaddr` at 21 with no load strobe and no memory enable until reset. Reset then returns it to word 0.
- R9: Operation code 110 maps to word 0, so fetch restarts without any routine running.
- R10: At most one load strobe is high in any cycle. `mem_rnw` is 1 whenever `mem_en` is 0.
- R11: The store routine loads MBR from the accumulator at word 14 (`ld_mbr`=1, `gate_en`=12'h010). It writes memory at word 15 with `mem_en`=1, `mem_rnw`=0, `gate_en`=12'h480 and no load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 4 | Instruction code from the instruction register; bit 0 is the immediate flag |
| acc_zero | input | 1 | Accumulator equals zero |
| acc_neg | input | 1 | Accumulator is negative |
| halt_req | input | 1 | Request to suspend fetching |
| uaddr | output | 5 | Address of the current microinstruction |
| gate_en | output | 12 | Bus gate enables |
| mem_en | output | 1 | Memory enable |
| mem_rnw | output | 1 | Memory direction, 1 = read |
| ld_pc | output | 1 | Program counter load strobe |
| ld_mar | output | 1 | Memory address register load strobe |
| ld_mbr | output | 1 | Memory buffer register load strobe |
| ld_ir | output | 1 | Instruction register load strobe |
| ld_acc | output | 1 | Accumulator load strobe |

## Verification
A wrong microprogram counter or a corrupted microinstruction shows at `uaddr` and on the control outputs in the very next cycle. The control word is registered together with the address, so the two can never drift apart for longer than one clock. A wrong map entry or a wrong condition selection therefore shows up one edge after the dispatching or branching word, as an unexpected `uaddr` and a mismatched strobe pattern. A sequencing fault that only skips a routine's final jump is exposed on the following cycle, when fetch word 0's `ld_mar` strobe fails to appear.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W    = 5;
    localparam int UWORDS  = 1 << UA_W;
    localparam int GATE_N  = 12;
    localparam int OPC_W   = 4;
    localparam int LOAD_N  = 5;
    localparam int CTL_W   = GATE_N + 2 + LOAD_N;

    // sequencing modes held in each microinstruction
    typedef enum logic [1:0] {
        LC_STEP     = 2'b00,
        LC_JUMP     = 2'b01,
        LC_BRANCH   = 2'b10,
        LC_DISPATCH = 2'b11
    } lc_e;

    // condition multiplexer selector
    typedef enum logic [1:0] {
        CS_ALWAYS   = 2'b00,
        CS_ACC_ZERO = 2'b01,
        CS_ACC_NEG  = 2'b10,
        CS_HALT     = 2'b11
    } cs_e;

    typedef struct packed {
        logic              ld_acc;
        logic              ld_ir;
        logic              ld_mbr;
        logic              ld_mar;
        logic              ld_pc;
        logic              mem_rnw;
        logic              mem_en;
        logic [GATE_N-1:0] gate;
    } ctl_t;

    typedef struct packed {
        logic [UA_W-1:0] next;
        lc_e             lc;
        cs_e             cs;
        ctl_t            ctl;
    } uinst_t;

    // bus gate assignments
    localparam int G_PC_MAR   = 0;
    localparam int G_INC_PC   = 1;
    localparam int G_IRA_MAR  = 2;
    localparam int G_IRA_ACC  = 3;
    localparam int G_ACC_MBR  = 4;
    localparam int G_MEM_MBR  = 5;
    localparam int G_MBR_BUS  = 6;
    localparam int G_MBR_MEM  = 7;
    localparam int G_IRA_PC   = 8;
    localparam int G_ACC_ALU  = 9;
    localparam int G_MEM_PORT = 10;
    localparam int G_ALU_ACC  = 11;

    // routine entry points and fixed microaddresses
    localparam logic [UA_W-1:0] UA_FETCH    = 5'd0;
    localparam logic [UA_W-1:0] UA_DISPATCH = 5'd4;
    localparam logic [UA_W-1:0] UA_LDA_IMM  = 5'd5;
    localparam logic [UA_W-1:0] UA_LDA_MEM  = 5'd6;
    localparam logic [UA_W-1:0] UA_ADD_IMM  = 5'd9;
    localparam logic [UA_W-1:0] UA_ADD_MEM  = 5'd10;
    localparam logic [UA_W-1:0] UA_STORE    = 5'd13;
    localparam logic [UA_W-1:0] UA_JUMP     = 5'd16;
    localparam logic [UA_W-1:0] UA_JZERO    = 5'd17;
    localparam logic [UA_W-1:0] UA_JNEG     = 5'd19;
    localparam logic [UA_W-1:0] UA_STOP     = 5'd21;
    localparam logic [UA_W-1:0] UA_HALT     = 5'd30;
    localparam logic [UA_W-1:0] UA_RESUME   = 5'd31;

endpackage

// File: rtl/useq_map.sv
module useq_map
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [UA_W-1:0]  entry
);

    logic [2:0] op;
    logic       imm;

    assign op  = opcode[OPC_W-1:1];
    assign imm = opcode[0];

    always_comb begin
        unique case (op)
            3'b000:  entry = imm ? UA_LDA_IMM : UA_LDA_MEM;
            3'b001:  entry = imm ? UA_ADD_IMM : UA_ADD_MEM;
            3'b010:  entry = UA_STORE;
            3'b011:  entry = UA_JUMP;
            3'b100:  entry = UA_JZERO;
            3'b101:  entry = UA_JNEG;
            3'b110:  entry = UA_FETCH;
            3'b111:  entry = UA_STOP;
            default: entry = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uinst_t          word
);

    always_comb begin
        word             = '0;
        word.ctl.mem_rnw = 1'b1;
        word.lc          = LC_JUMP;
        word.cs          = CS_ALWAYS;
        word.next        = UA_FETCH;
        case (addr)
            // fetch: MAR <- PC, divert to halt on request
            5'd0: begin
                word.ctl.gate[G_PC_MAR] = 1'b1;
                word.ctl.ld_mar         = 1'b1;
                word.lc                 = LC_BRANCH;
                word.cs                 = CS_HALT;
                word.next               = UA_HALT;
            end
            // PC <- PC + 1
            5'd1: begin
                word.ctl.gate[G_INC_PC] = 1'b1;
                word.ctl.ld_pc          = 1'b1;
                word.lc                 = LC_STEP;
            end
            // MBR <- M[MAR]
            5'd2: begin
                word.ctl.gate[G_MEM_MBR]  = 1'b1;
                word.ctl.gate[G_MEM_PORT] = 1'b1;
                word.ctl.mem_en           = 1'b1;
                word.ctl.ld_mbr           = 1'b1;
                word.lc                   = LC_STEP;
            end
            // IR <- MBR
            5'd3: begin
                word.ctl.gate[G_MBR_BUS] = 1'b1;
                word.ctl.ld_ir           = 1'b1;
                word.lc                  = LC_STEP;
            end
            // hand over to the routine for the new opcode
            5'd4: begin
                word.lc = LC_DISPATCH;
            end
            // load immediate
            5'd5: begin
                word.ctl.gate[G_IRA_ACC] = 1'b1;
                word.ctl.ld_acc          = 1'b1;
            end
            // load from memory / add from memory: MAR <- IR address
            5'd6, 5'd10, 5'd13: begin
                word.ctl.gate[G_IRA_MAR] = 1'b1;
                word.ctl.ld_mar          = 1'b1;
                word.lc                  = LC_STEP;
            end
            // operand read
            5'd7, 5'd11: begin
                word.ctl.gate[G_MEM_MBR]  = 1'b1;
                word.ctl.gate[G_MEM_PORT] = 1'b1;
                word.ctl.mem_en           = 1'b1;
                word.ctl.ld_mbr           = 1'b1;
                word.lc                   = LC_STEP;
            end
            // ACC <- MBR
            5'd8: begin
                word.ctl.gate[G_MBR_BUS] = 1'b1;
                word.ctl.ld_acc          = 1'b1;
            end
            // ACC <- ACC + IR address
            5'd9: begin
                word.ctl.gate[G_IRA_ACC] = 1'b1;
                word.ctl.gate[G_ACC_ALU] = 1'b1;
                word.ctl.gate[G_ALU_ACC] = 1'b1;
                word.ctl.ld_acc          = 1'b1;
            end
            // ACC <- ACC + MBR
            5'd12: begin
                word.ctl.gate[G_MBR_BUS] = 1'b1;
                word.ctl.gate[G_ACC_ALU] = 1'b1;
                word.ctl.gate[G_ALU_ACC] = 1'b1;
                word.ctl.ld_acc          = 1'b1;
            end
            // MBR <- ACC
            5'd14: begin
                word.ctl.gate[G_ACC_MBR] = 1'b1;
                word.ctl.ld_mbr          = 1'b1;
                word.lc                  = LC_STEP;
            end
            // M[MAR] <- MBR
            5'd15: begin
                word.ctl.gate[G_MBR_MEM]  = 1'b1;
                word.ctl.gate[G_MEM_PORT] = 1'b1;
                word.ctl.mem_en           = 1'b1;
                word.ctl.mem_rnw          = 1'b0;
            end
            // PC <- IR address
            5'd16: begin
                word.ctl.gate[G_IRA_PC] = 1'b1;
                word.ctl.ld_pc          = 1'b1;
            end
            // jump if zero
            5'd17: begin
                word.lc   = LC_BRANCH;
                word.cs   = CS_ACC_ZERO;
                word.next = UA_JUMP;
            end
            // jump if negative
            5'd19: begin
                word.lc   = LC_BRANCH;
                word.cs   = CS_ACC_NEG;
                word.next = UA_JUMP;
            end
            // stop: park here
            5'd21: begin
                word.next = UA_STOP;
            end
            // halt: wait while requested
            5'd30: begin
                word.lc   = LC_BRANCH;
                word.cs   = CS_HALT;
                word.next = UA_HALT;
            end
            default: begin
                word.lc   = LC_JUMP;
                word.next = UA_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] upc,
    input  lc_e             lc,
    input  cs_e             cs,
    input  logic [UA_W-1:0] next_fld,
    input  logic [UA_W-1:0] map_entry,
    input  logic            acc_zero,
    input  logic            acc_neg,
    input  logic            halt_req,
    output logic [UA_W-1:0] nxt
);

    logic            cond_hit;
    logic [UA_W-1:0] upc_inc;

    assign upc_inc = upc + 1'b1;

    always_comb begin
        unique case (cs)
            CS_ALWAYS:   cond_hit = 1'b1;
            CS_ACC_ZERO: cond_hit = acc_zero;
            CS_ACC_NEG:  cond_hit = acc_neg;
            CS_HALT:     cond_hit = halt_req;
            default:     cond_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (lc)
            LC_STEP:     nxt = upc_inc;
            LC_JUMP:     nxt = next_fld;
            LC_BRANCH:   nxt = cond_hit ? next_fld : upc_inc;
            LC_DISPATCH: nxt = map_entry;
            default:     nxt = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              acc_zero,
    input  logic              acc_neg,
    input  logic              halt_req,
    output logic [UA_W-1:0]   uaddr,
    output logic [GATE_N-1:0] gate_en,
    output logic              mem_en,
    output logic              mem_rnw,
    output logic              ld_pc,
    output logic              ld_mar,
    output logic              ld_mbr,
    output logic              ld_ir,
    output logic              ld_acc
);

    logic [UA_W-1:0] upc_q;
    uinst_t          mir_q;
    logic [UA_W-1:0] map_entry;
    logic [UA_W-1:0] nxt;
    logic [UA_W-1:0] rom_addr;
    uinst_t          rom_word;

    useq_map u_map (
        .opcode (opcode),
        .entry  (map_entry)
    );

    useq_next u_next (
        .upc       (upc_q),
        .lc        (mir_q.lc),
        .cs        (mir_q.cs),
        .next_fld  (mir_q.next),
        .map_entry (map_entry),
        .acc_zero  (acc_zero),
        .acc_neg   (acc_neg),
        .halt_req  (halt_req),
        .nxt       (nxt)
    );

    // the store is read at the address about to be taken, so the
    // microinstruction register always matches the counter
    assign rom_addr = rst_n ? nxt : UA_FETCH;

    useq_rom u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    // state register: microprogram counter and microinstruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc_q <= UA_FETCH;
        end else begin
            upc_q <= nxt;
        end
        mir_q <= rom_word;
    end

    // outputs
    always_comb begin
        uaddr   = upc_q;
        gate_en = mir_q.ctl.gate;
        mem_en  = mir_q.ctl.mem_en;
        mem_rnw = mir_q.ctl.mem_rnw;
        ld_pc   = mir_q.ctl.ld_pc;
        ld_mar  = mir_q.ctl.ld_mar;
        ld_mbr  = mir_q.ctl.ld_mbr;
        ld_ir   = mir_q.ctl.ld_ir;
        ld_acc  = mir_q.ctl.ld_acc;
    end

endmodule

// File: rtl/useq_chk.sv
module useq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] upc,
    input logic [1:0] lc,
    input logic [1:0] cs,
    input logic [4:0] next_fld,
    input logic [4:0] map_entry,
    input logic       acc_zero,
    input logic       acc_neg,
    input logic       halt_req,
    input logic [4:0] loads,
    input logic       mem_en,
    input logic       mem_rnw
);

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (lc == 2'b00) |=> (upc == $past(upc) + 5'd1)); // R2

    AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lc == 2'b11) |=> (upc == $past(map_entry))); // R3

    AST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (lc == 2'b01) |=> (upc == $past(next_fld))); // R4

    AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lc == 2'b10 && cs == 2'b01 && acc_zero) |=> (upc == $past(next_fld))); // R5

    AST_NEG_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (lc == 2'b10 && cs == 2'b10 && !acc_neg) |=> (upc == $past(upc) + 5'd1)); // R6

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 5'd30 && halt_req) |=> (upc == 5'd30)); // R7

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loads)); // R10

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> mem_rnw); // R10

endmodule

bind useq_ctrl useq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upc       (upc_q),
    .lc        (mir_q.lc),
    .cs        (mir_q.cs),
    .next_fld  (mir_q.next),
    .map_entry (map_entry),
    .acc_zero  (acc_zero),
    .acc_neg   (acc_neg),
    .halt_req  (halt_req),
    .loads     ({ld_acc, ld_ir, ld_mbr, ld_mar, ld_pc}),
    .mem_en    (mem_en),
    .mem_rnw   (mem_rnw)
);

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic        acc_zero = 1'b0;
    logic        acc_neg = 1'b0;
    logic        halt_req = 1'b0;
    logic [4:0]  uaddr;
    logic [11:0] gate_en;
    logic        mem_en, mem_rnw, ld_pc, ld_mar, ld_mbr, ld_ir, ld_acc;

    int n_chk = 0;
    int n_err = 0;
    int multi_load = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    useq_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg),
        .halt_req (halt_req),
        .uaddr    (uaddr),
        .gate_en  (gate_en),
        .mem_en   (mem_en),
        .mem_rnw  (mem_rnw),
        .ld_pc    (ld_pc),
        .ld_mar   (ld_mar),
        .ld_mbr   (ld_mbr),
        .ld_ir    (ld_ir),
        .ld_acc   (ld_acc)
    );

    // loads packed as {acc, ir, mbr, mar, pc}
    function automatic logic [4:0] loads();
        return {ld_acc, ld_ir, ld_mbr, ld_mar, ld_pc};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input int ua, input int g,
                            input logic [4:0] ld, input bit me, input bit rnw);
        chk(uaddr == ua[4:0], req, "uaddr", uaddr, ua);
        chk(gate_en == g[11:0], req, "gate_en", gate_en, g);
        chk(loads() == ld, req, "loads", loads(), ld);
        chk(mem_en == me && mem_rnw == rnw, req, "mem_en/rnw",
            {mem_en, mem_rnw}, {me, rnw});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // R10 monitor, reported once at the end
    always @(negedge clk) begin
        if (rst_n && (($countones(loads()) > 1) || (!mem_en && !mem_rnw)))
            multi_load++;
    end

    // runs fetch from word 0 and checks the dispatch target
    task automatic go_fetch(input logic [3:0] op, input int entry);
        opcode = op;
        tick(); chk_word("R2", 1, 12'h002, 5'b00001, 0, 1);
        tick(); chk_word("R2", 2, 12'h420, 5'b00100, 1, 1);
        tick(); chk_word("R2", 3, 12'h040, 5'b01000, 0, 1);
        tick(); chk_word("R2", 4, 12'h000, 5'b00000, 0, 1);
        tick(); chk(uaddr == entry[4:0], "R3", "dispatch target", uaddr, entry);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk_word("R1", 0, 12'h001, 5'b00010, 0, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_lda_imm();
        go_fetch(4'b0001, 5);
        chk_word("R4", 5, 12'h008, 5'b10000, 0, 1);
        tick(); chk(uaddr == 5'd0, "R4", "return to fetch", uaddr, 0);
    endtask

    task automatic t_add_mem();
        go_fetch(4'b0010, 10);
        tick(); chk_word("R4", 11, 12'h420, 5'b00100, 1, 1);
        tick(); chk_word("R4", 12, 12'hA40, 5'b10000, 0, 1);
        tick(); chk(uaddr == 5'd0, "R4", "return to fetch", uaddr, 0);
    endtask

    task automatic t_store();
        go_fetch(4'b0100, 13);
        tick(); chk_word("R11", 14, 12'h010, 5'b00100, 0, 1);
        tick(); chk_word("R11", 15, 12'h480, 5'b00000, 1, 0);
        tick(); chk(uaddr == 5'd0, "R11", "return to fetch", uaddr, 0);
    endtask

    task automatic t_branch(input logic [3:0] op, input int entry,
                            input bit z, input bit n, input int exp_ua,
                            input string req);
        acc_zero = z;
        acc_neg  = n;
        go_fetch(op, entry);
        tick(); chk(uaddr == exp_ua[4:0], req, "branch result", uaddr, exp_ua);
        if (exp_ua == 16)
            chk_word(req, 16, 12'h100, 5'b00001, 0, 1);
        tick(); chk(uaddr == 5'd0, req, "return to fetch", uaddr, 0);
        acc_zero = 1'b0;
        acc_neg  = 1'b0;
    endtask

    task automatic t_jump();
        go_fetch(4'b0110, 16);
        chk_word("R3", 16, 12'h100, 5'b00001, 0, 1);
        tick(); chk(uaddr == 5'd0, "R4", "return to fetch", uaddr, 0);
    endtask

    task automatic t_halt();
        halt_req = 1'b1;
        tick(); chk(uaddr == 5'd30, "R7", "enter halt", uaddr, 30);
        repeat (4) tick();
        chk_word("R7", 30, 12'h000, 5'b00000, 0, 1);
        halt_req = 1'b0;
        tick(); chk(uaddr == 5'd31, "R7", "leave halt", uaddr, 31);
        tick(); chk(uaddr == 5'd0, "R7", "resume fetch", uaddr, 0);
    endtask

    task automatic t_unused();
        go_fetch(4'b1100, 0);
        chk_word("R9", 0, 12'h001, 5'b00010, 0, 1);
    endtask

    task automatic t_stop();
        go_fetch(4'b1110, 21);
        repeat (6) tick();
        chk_word("R8", 21, 12'h000, 5'b00000, 0, 1);
        rst_n = 1'b0;
        tick(); tick();
        chk(uaddr == 5'd0, "R8", "reset leaves stop", uaddr, 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        tick();
        t_reset();
        t_lda_imm();
        t_add_mem();
        t_store();
        t_jump();
        t_branch(4'b1000, 17, 1, 0, 16, "R5");
        t_branch(4'b1000, 17, 0, 1, 18, "R6");
        t_branch(4'b1010, 19, 0, 1, 16, "R5");
        t_branch(4'b1010, 19, 1, 0, 20, "R6");
        t_halt();
        t_unused();
        t_stop();
        chk(multi_load == 0, "R10", "strobe conflicts", multi_load, 0);
        finish_run();
    end

endmodule